// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block keeps per-instruction exception state for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Each instruction carries a small cause vector from stage to stage. Any stage can set its own bit in the vector of the instruction it currently holds. An instruction whose vector is nonzero is never allowed to write memory or the register file. A younger instruction is also refused its memory write while an older faulting instruction sits in write-back.

Nothing is acted on until the instruction reaches write-back. At that point a nonzero vector raises a one-cycle trap request. The trap reports a prioritised cause code, saves the faulting PC, redirects fetch to a fixed handler address, and flushes every younger stage to a bubble. Because faults are handled only at write-back, the oldest instruction's fault is always the one taken. This holds even when a younger instruction raised its fault earlier in time. Every older instruction retires normally, and the faulting instruction and everything after it can be restarted.

Top module: `exc_tracker`

## Requirements
- R1: After reset, every stage holds a bubble: `trap_req`, `flush`, `mem_wr_allow` and `rf_wr_allow` are all 0.
- R2: The pipeline advances one stage per clock. A fault-free instruction presented at fetch in cycle t is in memory in cycle t+3, with `mem_wr_allow`=1. It is in write-back in cycle t+4, with `rf_wr_allow`=1 and `retire_pc` equal to its fetch PC.
- R3: A cause input is recorded in the vector of the instruction that occupies the matching stage in that cycle. `if_fetch_fault` goes with fetch, `id_undef_op` with decode, `ex_overflow` with execute and `mem_data_fault` with memory.
- R4: A cause input that is raised while its stage holds a bubble (`if_valid`=0 at fetch) has no effect: no trap and no write suppression result from it.
- R5: `mem_wr_allow` is 0 when the instruction in memory has any cause, including `mem_data_fault` in the same cycle. It is also 0 while the instruction in write-back has a nonzero vector.
- R6: `rf_wr_allow` is 0 for an instruction in write-back with a nonzero vector.
- R7: `trap_req` and `flush` are 1 in exactly the cycle a valid instruction with a nonzero vector is in write-back. `trap_epc` then equals its PC and `redirect_pc` equals the handler address parameter (default 0x80).
- R8: The cause code uses fixed priority: fetch fault = 1 beats undefined opcode = 2, which beats overflow = 3, which beats data fault = 4.
- R9: Faults are taken in program order. When an older instruction faults later in time than a younger one, the older one traps and the younger one never traps.
- R10: In the cycle after a trap, every stage from decode through write-back holds a bubble, and neither write permit is set.
- R11: An instruction older than a faulting one retires with `rf_wr_allow`=1 in the cycle before the trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | 1 | Fetch stage holds a real instruction |
| if_pc | input | PC_W | PC of the instruction in fetch |
| if_fetch_fault | input | 1 | Fetch fault for the instruction in fetch |
| id_undef_op | input | 1 | Undefined opcode for the instruction in decode |
| ex_overflow | input | 1 | Arithmetic overflow for the instruction in execute |
| mem_data_fault | input | 1 | Data-access fault for the instruction in memory |
| trap_req | output | 1 | Trap taken this cycle |
| trap_cause | output | 3 | Prioritised cause code (0 when no trap) |
| trap_epc | output | PC_W | PC of the faulting instruction |
| redirect_pc | output | PC_W | Handler address when trapping, else 0 |
| flush | output | 1 | Turn all younger stages into bubbles |
| mem_wr_allow | output | 1 | The instruction in memory may write memory |
| rf_wr_allow | output | 1 | The instruction in write-back may write the register file |
| retire_pc | output | PC_W | PC of the instruction in write-back |

## Verification
Assertions check the cycle-to-cycle invariants on every clock. Bubbles carry empty vectors, and valid instructions advance unless flushed. A flush leaves every stage empty. A trap never repeats in the next cycle, trap cycles never grant a write, and the cause code stays in its legal range. Other behaviour can only be shown by the bench's directed scenarios. These include which instruction a stage cause lands on, the exact code chosen when several causes meet, the saved PC, and that the older fault wins over a younger one raised earlier. They also include that causes raised on bubbles vanish and that older work retires before the trap.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NCAUSE = 4;
    localparam int CODE_W = 3;

    // bit order is the priority order: lower index = earlier stage = wins
    typedef struct packed {
        logic dmem;
        logic ovf;
        logic undef;
        logic ifetch;
    } cause_t;

    typedef enum logic [CODE_W-1:0] {
        CODE_NONE   = 3'd0,
        CODE_IFETCH = 3'd1,
        CODE_UNDEF  = 3'd2,
        CODE_OVF    = 3'd3,
        CODE_DMEM   = 3'd4
    } code_e;

    function automatic cause_t cause_bit(input int idx);
        logic [NCAUSE-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return cause_t'(v);
    endfunction

    function automatic code_e pick_code(input cause_t c);
        if (c.ifetch)     return CODE_IFETCH;
        else if (c.undef) return CODE_UNDEF;
        else if (c.ovf)   return CODE_OVF;
        else if (c.dmem)  return CODE_DMEM;
        else              return CODE_NONE;
    endfunction

    function automatic logic any_cause(input cause_t c);
        return |c;
    endfunction

endpackage

// File: rtl/exc_stage.sv
module exc_stage
    import exc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int SLOT = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  cause_t          in_cause,
    input  logic            raise,
    output logic            valid,
    output logic [PC_W-1:0] pc,
    output cause_t          cause_live
);

    cause_t held;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
            pc    <= '0;
            held  <= '0;
        end else begin
            valid <= in_valid;
            pc    <= in_valid ? in_pc : '0;
            held  <= in_valid ? in_cause : '0;
        end
    end

    always_comb begin
        cause_live = held;
        if (valid && raise) cause_live = cause_live | cause_bit(SLOT);
    end

    // R4
    bubble_clean_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (held == '0 && cause_live == '0));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush) |=> valid);

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_valid,
    input  logic [PC_W-1:0]   wb_pc,
    input  cause_t            wb_cause,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_cause,
    output logic [PC_W-1:0]   trap_epc,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              flush
);

    logic take;

    always_comb begin
        take        = wb_valid && any_cause(wb_cause);
        trap_req    = take;
        flush       = take;
        trap_cause  = take ? pick_code(wb_cause) : CODE_NONE;
        trap_epc    = take ? wb_pc : '0;
        redirect_pc = take ? HANDLER_PC : '0;
    end

    // R8
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_cause != 3'd0 && trap_cause <= 3'd4));

endmodule

// File: rtl/exc_wgate.sv
module exc_wgate
    import exc_pkg::*;
(
    input  logic   mem_valid,
    input  cause_t mem_cause,
    input  logic   wb_valid,
    input  cause_t wb_cause,
    output logic   mem_wr_allow,
    output logic   rf_wr_allow
);

    logic wb_bad;

    always_comb begin
        wb_bad       = wb_valid && any_cause(wb_cause);
        rf_wr_allow  = wb_valid && !any_cause(wb_cause);
        mem_wr_allow = mem_valid && !any_cause(mem_cause) && !wb_bad;
    end

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
    import exc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              if_valid,
    input  logic [PC_W-1:0]   if_pc,
    input  logic              if_fetch_fault,
    input  logic              id_undef_op,
    input  logic              ex_overflow,
    input  logic              mem_data_fault,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_cause,
    output logic [PC_W-1:0]   trap_epc,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              flush,
    output logic              mem_wr_allow,
    output logic              rf_wr_allow,
    output logic [PC_W-1:0]   retire_pc
);

    localparam int NSTG = 4;       // decode, execute, memory, write-back
    localparam int WB   = NSTG;
    localparam int MEM  = NSTG - 1;

    logic            v     [0:NSTG];
    logic [PC_W-1:0] pc    [0:NSTG];
    cause_t          live  [0:NSTG];
    logic            raise [1:NSTG];

    assign v[0]     = if_valid;
    assign pc[0]    = if_pc;
    assign live[0]  = (if_valid && if_fetch_fault) ? cause_bit(0) : cause_t'('0);
    assign raise[1] = id_undef_op;
    assign raise[2] = ex_overflow;
    assign raise[3] = mem_data_fault;
    assign raise[4] = 1'b0;

    genvar k;
    generate
        for (k = 1; k <= NSTG; k++) begin : g_stage
            exc_stage #(
                .PC_W (PC_W),
                .SLOT ((k < NSTG) ? k : 0)
            ) u_stage (
                .clk        (clk),
                .rst        (rst),
                .flush      (flush),
                .in_valid   (v[k-1]),
                .in_pc      (pc[k-1]),
                .in_cause   (live[k-1]),
                .raise      (raise[k]),
                .valid      (v[k]),
                .pc         (pc[k]),
                .cause_live (live[k])
            );
        end
    endgenerate

    exc_commit #(
        .PC_W       (PC_W),
        .HANDLER_PC (HANDLER_PC)
    ) u_commit (
        .clk         (clk),
        .rst         (rst),
        .wb_valid    (v[WB]),
        .wb_pc       (pc[WB]),
        .wb_cause    (live[WB]),
        .trap_req    (trap_req),
        .trap_cause  (trap_cause),
        .trap_epc    (trap_epc),
        .redirect_pc (redirect_pc),
        .flush       (flush)
    );

    exc_wgate u_wgate (
        .mem_valid    (v[MEM]),
        .mem_cause    (live[MEM]),
        .wb_valid     (v[WB]),
        .wb_cause     (live[WB]),
        .mem_wr_allow (mem_wr_allow),
        .rf_wr_allow  (rf_wr_allow)
    );

    assign retire_pc = pc[WB];

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!v[1] && !v[2] && !v[3] && !v[4]));

    // R9
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req);

    // R6
    rf_vs_trap_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_allow |-> !trap_req);

    // R5
    mem_vs_trap_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> !mem_wr_allow);

endmodule

// File: tb/exc_tracker_test.sv
module exc_tracker_test;

    localparam int PC_W = 32;
    localparam logic [PC_W-1:0] HVEC = 32'h0000_0080;

    logic            clk = 1'b0;
    logic            rst;
    logic            if_valid, if_fetch_fault, id_undef_op, ex_overflow, mem_data_fault;
    logic [PC_W-1:0] if_pc;
    logic            trap_req, flush, mem_wr_allow, rf_wr_allow;
    logic [2:0]      trap_cause;
    logic [PC_W-1:0] trap_epc, redirect_pc, retire_pc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    exc_tracker #(.PC_W(PC_W), .HANDLER_PC(HVEC)) uut (
        .clk(clk), .rst(rst), .if_valid(if_valid), .if_pc(if_pc),
        .if_fetch_fault(if_fetch_fault), .id_undef_op(id_undef_op),
        .ex_overflow(ex_overflow), .mem_data_fault(mem_data_fault),
        .trap_req(trap_req), .trap_cause(trap_cause), .trap_epc(trap_epc),
        .redirect_pc(redirect_pc), .flush(flush), .mem_wr_allow(mem_wr_allow),
        .rf_wr_allow(rf_wr_allow), .retire_pc(retire_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle's inputs (called right after a falling edge)
    task automatic put(input logic v, input logic [PC_W-1:0] p,
                       input logic f_if, input logic f_id, input logic f_ex, input logic f_mem);
        if_valid = v; if_pc = p; if_fetch_fault = f_if;
        id_undef_op = f_id; ex_overflow = f_ex; mem_data_fault = f_mem;
        #1;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain;
        for (int i = 0; i < 6; i++) begin
            put(0, 0, 0, 0, 0, 0);
            tick();
        end
    endtask

    task automatic t_reset;
        check("R1 trap", trap_req, 0);
        check("R1 flush", flush, 0);
        check("R1 mem_wr", mem_wr_allow, 0);
        check("R1 rf_wr", rf_wr_allow, 0);
    endtask

    task automatic t_clean;
        put(1, 32'h100, 0, 0, 0, 0); tick();
        put(1, 32'h104, 0, 0, 0, 0); tick();
        put(1, 32'h108, 0, 0, 0, 0); tick();
        put(0, 0, 0, 0, 0, 0);
        check("R2 mem_wr at t+3", mem_wr_allow, 1);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R2 rf_wr at t+4", rf_wr_allow, 1);
        check("R2 retire_pc", retire_pc, 32'h100);
        check("R2 no trap", trap_req, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R2 next retire", retire_pc, 32'h104);
        drain();
    endtask

    task automatic t_overflow;
        put(1, 32'h200, 0, 0, 0, 0); tick();
        put(1, 32'h204, 0, 0, 0, 0); tick();
        put(1, 32'h208, 0, 0, 1, 0); tick();     // 0x200 in execute
        put(1, 32'h20c, 0, 0, 0, 0);
        check("R5 faulty in mem", mem_wr_allow, 0);
        tick();
        put(1, 32'h210, 0, 0, 0, 0);
        check("R7 trap", trap_req, 1);
        check("R7 flush", flush, 1);
        check("R3 overflow code", trap_cause, 3);
        check("R7 epc", trap_epc, 32'h200);
        check("R7 redirect", redirect_pc, HVEC);
        check("R6 rf blocked", rf_wr_allow, 0);
        check("R5 younger mem blocked", mem_wr_allow, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R10 no trap after", trap_req, 0);
        check("R10 rf empty", rf_wr_allow, 0);
        check("R10 mem empty", mem_wr_allow, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R10 still empty", rf_wr_allow, 0);
        drain();
    endtask

    task automatic t_order;
        // older 0x300 faults in memory; younger 0x304 faults at fetch earlier
        put(1, 32'h300, 0, 0, 0, 0); tick();
        put(1, 32'h304, 1, 0, 0, 0); tick();
        put(0, 0, 0, 0, 0, 0); tick();
        put(0, 0, 0, 0, 1, 0);
        check("R5 same-cycle data fault", mem_wr_allow, 1);
        put(0, 0, 0, 0, 0, 1);
        check("R5 same-cycle data fault", mem_wr_allow, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R9 older trap", trap_req, 1);
        check("R9 older epc", trap_epc, 32'h300);
        check("R9 data code", trap_cause, 4);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R9 younger never traps", trap_req, 0);
        tick();
        check("R9 younger never traps", trap_req, 0);
        drain();
    endtask

    task automatic t_priority;
        put(1, 32'h400, 1, 0, 0, 0); tick();
        put(0, 0, 0, 1, 0, 0); tick();
        put(0, 0, 0, 0, 1, 0); tick();
        put(0, 0, 0, 0, 0, 1); tick();
        put(0, 0, 0, 0, 0, 0);
        check("R8 fetch beats all", trap_cause, 1);
        drain();
        put(1, 32'h404, 0, 0, 0, 0); tick();
        put(0, 0, 0, 0, 0, 0); tick();
        put(0, 0, 0, 0, 1, 0); tick();
        put(0, 0, 0, 0, 0, 1); tick();
        put(0, 0, 0, 0, 0, 0);
        check("R8 overflow beats data", trap_cause, 3);
        drain();
    endtask

    task automatic t_bubbles;
        put(0, 32'h500, 1, 0, 0, 0); tick();
        put(0, 0, 0, 1, 0, 0); tick();
        put(0, 0, 0, 0, 1, 0); tick();
        put(0, 0, 0, 0, 0, 1);
        check("R4 mem bubble", mem_wr_allow, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R4 no trap from bubbles", trap_req, 0);
        tick();
        check("R4 no trap later", trap_req, 0);
        drain();
    endtask

    task automatic t_older_retires;
        put(1, 32'h600, 0, 0, 0, 0); tick();
        put(1, 32'h604, 0, 0, 0, 0); tick();
        put(0, 0, 0, 1, 0, 0); tick();           // 0x604 in decode
        put(0, 0, 0, 0, 0, 0); tick();
        put(0, 0, 0, 0, 0, 0);
        check("R11 older retires", rf_wr_allow, 1);
        check("R11 older pc", retire_pc, 32'h600);
        check("R11 no trap yet", trap_req, 0);
        check("R5 faulty mem blocked", mem_wr_allow, 0);
        tick();
        put(0, 0, 0, 0, 0, 0);
        check("R11 trap next", trap_req, 1);
        check("R3 undef code", trap_cause, 2);
        check("R11 epc", trap_epc, 32'h604);
        drain();
    endtask

    initial begin
        rst = 1'b1;
        put(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_clean();
        t_overflow();
        t_order();
        t_priority();
        t_bubbles();
        t_older_retires();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule